// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Datapath

This block is a fixed-point arithmetic datapath built around a signed 16x16 multiplier and two 36-bit accumulators. A 16-bit x operand and a 32-bit y register are loaded through strobes. The signed product of x and the upper half of y is sign-extended to 36 bits. It is then rescaled by one of four alignment settings, and added to an accumulator, subtracted from it, or copied into it. A further command loads a 16-bit value into the upper part of an accumulator.

A 9-bit control register sets the behaviour. It holds the alignment setting, a saturation disable for each accumulator, and clear-inhibit bits for the low halves of both accumulators and of y. It also holds a squaring mode, in which a load of the upper half of y writes x as well. Each accumulate command updates a status word. The status word carries sign, zero, carry and signed-overflow flags for the last result, a sticky overflow bit for each accumulator, and the top four bits of each accumulator.

A small register port reads and writes the control word and the status word, and reads the operand registers back. Every command takes one clock.

Top module: `mac_datapath`

## Requirements
- R1: The control word keeps bits [8:0] of a write to address 0 and reads back on address 0 with bits [15:9] as zero. It is zero after reset.
- R2: The product is signed x times the signed upper half of y, sign-extended to 36 bits. Control bits [1:0] scale it before use. 00 leaves it unchanged. 11 shifts it left by one. 10 shifts it left by two. 01 shifts it right by two with sign extension.
- R3: acc_dst selects the accumulator (0 = a0, 1 = a1). acc_op 00 adds the scaled product and 01 subtracts it. 10 loads the scaled product. 11 loads opnd into bits [31:16], sign-extends it through bit 35, and clears bits [15:0].
- R4: The multiplier uses the operand registers as they stand before the clock edge, so an operand load in the same cycle as a command does not affect that command. The accumulator and all flags are written on the same edge.
- R5: Status bit 15 is set when bit 35 of the value written to the accumulator is 1. Status bit 14 is set when that value is zero.
- R6: When an add or subtract overflows 36-bit two's complement, the accumulator is clamped to 0x7_FFFF_FFFF (positive overflow) or 0x8_0000_0000 (negative overflow). Control bit 2 (a0) or bit 3 (a1), when set, disables the clamp and the result wraps.
- R7: Status bit 12 reports signed overflow of the true add or subtract result. Status bit 13 reports the carry out of bit 35, where subtraction adds the inverted product plus one. Both flags are zero after the two load commands.
- R8: Status bit 10 (a0) and status bit 11 (a1) are sticky overflow bits. Each is set by an overflow on its own accumulator and cleared by any write to address 1 or by reset. Status [3:0] shows a0[35:32], [7:4] shows a1[35:32], and [9:8] reads zero.
- R9: Control bit 4 (a0) or bit 5 (a1), when set, keeps the accumulator's low 16 bits during a high-part load. Control bit 6, when set, keeps the low half of y during a load of the upper half of y, which otherwise clears it. A low-half load of y in the same cycle takes priority.
- R10: With control bit 7 set, a load of the upper half of y also writes the same value into x.
- R11: Address 2 reads x, address 3 reads the upper half of y, address 4 reads the low half of y, and every other address except 0 and 1 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| opnd | input | 16 | Operand data for loads and high-part accumulator load |
| ld_x | input | 1 | Load x from opnd |
| ld_yh | input | 1 | Load upper half of y from opnd |
| ld_yl | input | 1 | Load low half of y from opnd |
| acc_go | input | 1 | Execute accumulator command |
| acc_op | input | 2 | Accumulator command code |
| acc_dst | input | 1 | Target accumulator |
| acc0 | output | 36 | Accumulator a0 |
| acc1 | output | 36 | Accumulator a1 |

## Verification
Every register result (accumulators, flags, sticky bits, operand registers and control word) is due right after the first rising edge that follows the strobe. The read data follows the address with no clock. The bench drives each stimulus, waits for one rising edge and then 1 ns more, and then sets the read address and lets it settle for 1 ns before it compares. Same-cycle operand loads combined with a command check that the command still sees the operands from before the edge.

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int DW = 16,
  parameter int AW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] opnd,
  input  logic          ld_x,
  input  logic          ld_yh,
  input  logic          ld_yl,
  input  logic          acc_go,
  input  logic [1:0]    acc_op,
  input  logic          acc_dst,
  output logic [AW-1:0] acc0,
  output logic [AW-1:0] acc1
);
  localparam int PW = 2 * DW;
  localparam int CW = 9;
  localparam logic [AW-1:0] POS_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_MAX = {1'b1, {(AW-1){1'b0}}};
  localparam logic [1:0] OP_ADD = 2'd0, OP_SUB = 2'd1, OP_LDP = 2'd2;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_X = 3'd2, A_YH = 3'd3, A_YL = 3'd4;

  logic [CW-1:0] ctrl;
  logic [DW-1:0] x_q, yh_q, yl_q;
  logic [AW-1:0] acc_q [2];
  logic          lmi, leq, llv, lmv;
  logic [1:0]    ovs;

  wire [1:0] align    = ctrl[1:0];
  wire [1:0] sat_off  = ctrl[3:2];
  wire [1:0] keep_alo = ctrl[5:4];
  wire       keep_ylo = ctrl[6];
  wire       square   = ctrl[7];

  wire signed [PW-1:0] prod = $signed(x_q) * $signed(yh_q);
  wire signed [AW-1:0] pext = {{(AW-PW){prod[PW-1]}}, prod};

  logic [AW-1:0] pal;
  always_comb
    case (align)
      2'b00:   pal = pext;
      2'b01:   pal = pext >>> 2;
      2'b10:   pal = pext << 2;
      default: pal = pext << 1;
    endcase

  wire [AW-1:0] cur    = acc_q[acc_dst];
  wire          is_sub = (acc_op == OP_SUB);
  wire [AW-1:0] addend = is_sub ? ~pal : pal;
  wire [AW:0]   usum   = {1'b0, cur} + {1'b0, addend} + {{AW{1'b0}}, is_sub};
  wire          ovf    = (cur[AW-1] == addend[AW-1]) && (usum[AW-1] != cur[AW-1]);
  wire [AW-1:0] hi_val = {{(AW-PW){opnd[DW-1]}}, opnd,
                          keep_alo[acc_dst] ? cur[DW-1:0] : {DW{1'b0}}};

  logic [AW-1:0] nxt;
  logic          n_llv, n_lmv;
  always_comb begin
    n_llv = 1'b0;
    n_lmv = 1'b0;
    case (acc_op)
      OP_ADD, OP_SUB: begin
        n_llv = usum[AW];
        n_lmv = ovf;
        nxt   = (ovf && !sat_off[acc_dst]) ? (cur[AW-1] ? NEG_MAX : POS_MAX) : usum[AW-1:0];
      end
      OP_LDP:  nxt = pal;
      default: nxt = hi_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl     <= '0;
      x_q      <= '0;
      yh_q     <= '0;
      yl_q     <= '0;
      acc_q[0] <= '0;
      acc_q[1] <= '0;
      lmi      <= 1'b0;
      leq      <= 1'b0;
      llv      <= 1'b0;
      lmv      <= 1'b0;
      ovs      <= 2'b00;
    end else begin
      if (reg_we && reg_addr == A_CTRL) ctrl <= reg_wdata[CW-1:0];
      if (reg_we && reg_addr == A_STAT) ovs <= 2'b00;
      if (ld_x) x_q <= opnd;
      if (ld_yh) begin
        yh_q <= opnd;
        if (square) x_q <= opnd;
        if (!keep_ylo) yl_q <= '0;
      end
      if (ld_yl) yl_q <= opnd;
      if (acc_go) begin
        acc_q[acc_dst] <= nxt;
        lmi <= nxt[AW-1];
        leq <= (nxt == '0);
        llv <= n_llv;
        lmv <= n_lmv;
        if (n_lmv) ovs[acc_dst] <= 1'b1;
      end
    end

  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];

  wire [DW-1:0] stat = DW'({lmi, leq, llv, lmv, ovs[1], ovs[0], 2'b00,
                            acc_q[1][AW-1:AW-4], acc_q[0][AW-1:AW-4]});

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'(ctrl);
      A_STAT:  reg_rdata = stat;
      A_X:     reg_rdata = x_q;
      A_YH:    reg_rdata = yh_q;
      A_YL:    reg_rdata = yl_q;
      default: reg_rdata = '0;
    endcase

  // R6
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go && !acc_op[1] && ovf && !sat_off[acc_dst]
      |=> (acc_q[$past(acc_dst)] == POS_MAX) || (acc_q[$past(acc_dst)] == NEG_MAX));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovs[0] && !(reg_we && reg_addr == A_STAT) |=> ovs[0]);

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go && n_lmv |=> lmv && ovs[$past(acc_dst)]);

  // R9
  ylo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_yh && keep_ylo && !ld_yl |=> yl_q == $past(yl_q));

  // R10
  square_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_yh && square |=> x_q == yh_q);

  // R5
  leq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> leq == (acc_q[$past(acc_dst)] == '0));
endmodule

// File: tb/sim_mac_datapath.sv
`timescale 1ns/1ps
module sim_mac_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [15:0] opnd = 16'd0;
  logic        ld_x = 1'b0, ld_yh = 1'b0, ld_yl = 1'b0;
  logic        acc_go = 1'b0;
  logic [1:0]  acc_op = 2'd0;
  logic        acc_dst = 1'b0;
  logic [35:0] acc0, acc1;

  always #2.5 clk = ~clk;

  mac_datapath u0 (.*);

  typedef struct {
    int          kind;
    logic [35:0] val;
    string       req;
  } exp_t;

  exp_t  q[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  exp_t  e;
  logic [35:0] act;

  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      e = q.pop_front();
      act = (e.kind == 0) ? acc0 : (e.kind == 1) ? acc1 : {20'd0, reg_rdata};
      n_chk++;
      if (act !== e.val) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", e.req, act, e.val);
      end
    end
  end

  logic [8:0]  m_ctrl = '0;
  logic [15:0] m_x = '0, m_yh = '0, m_yl = '0;
  logic [35:0] m_a [2] = '{36'd0, 36'd0};
  logic        m_lmi = 0, m_leq = 0, m_llv = 0, m_lmv = 0;
  logic [1:0]  m_ov = '0;
  localparam longint MAXL = (64'sd1 <<< 35) - 1;
  localparam longint MINL = -(64'sd1 <<< 35);

  function automatic logic [35:0] scaled();
    longint p = longint'($signed(m_x)) * longint'($signed(m_yh));
    case (m_ctrl[1:0])
      2'd1: p = p >>> 2;
      2'd2: p = p * 4;
      2'd3: p = p * 2;
      default: ;
    endcase
    return p[35:0];
  endfunction

  function automatic logic [15:0] mstat();
    return {m_lmi, m_leq, m_llv, m_lmv, m_ov[1], m_ov[0], 2'b00, m_a[1][35:32], m_a[0][35:32]};
  endfunction

  task automatic push(int kind, logic [35:0] val, string req);
    exp_t t;
    t.kind = kind; t.val = val; t.req = req;
    q.push_back(t);
  endtask

  task automatic flush();
    #1;
    -> chk_ev;
    wait (q.size() == 0);
  endtask

  task automatic chk_read(logic [2:0] a, logic [15:0] v, string req);
    reg_addr = a;
    push(2, {20'd0, v}, req);
    flush();
  endtask

  task automatic chk_state(string req);
    reg_addr = 3'd1;
    push(0, m_a[0], req);
    push(1, m_a[1], req);
    push(2, {20'd0, mstat()}, req);
    flush();
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (a == 3'd0) m_ctrl = d[8:0];
    if (a == 3'd1) m_ov = '0;
  endtask

  task automatic ld(int which, logic [15:0] d);
    opnd = d;
    ld_x = (which == 0); ld_yh = (which == 1); ld_yl = (which == 2);
    @(posedge clk); #1;
    ld_x = 0; ld_yh = 0; ld_yl = 0;
    if (which == 0) m_x = d;
    if (which == 1) begin
      m_yh = d;
      if (m_ctrl[7]) m_x = d;
      if (!m_ctrl[6]) m_yl = '0;
    end
    if (which == 2) m_yl = d;
  endtask

  task automatic model_acc(logic [1:0] op, logic d, logic [15:0] data);
    logic [35:0] al = scaled();
    logic [35:0] res;
    longint sa = longint'($signed(m_a[d]));
    longint sp = longint'($signed(al));
    longint ua = longint'({28'd0, m_a[d]});
    longint up = longint'({28'd0, al});
    longint t;
    m_llv = 0; m_lmv = 0;
    if (op == 2'd0 || op == 2'd1) begin
      t = (op == 2'd1) ? sa - sp : sa + sp;
      m_lmv = (t > MAXL) || (t < MINL);
      m_llv = (op == 2'd0) ? (ua + up > 64'h0000000FFFFFFFFF) : (ua >= up);
      if (m_lmv && !m_ctrl[2 + d]) res = (t < 0) ? 36'h800000000 : 36'h7FFFFFFFF;
      else res = t[35:0];
      if (m_lmv) m_ov[d] = 1'b1;
    end else if (op == 2'd2) res = al;
    else res = {{4{data[15]}}, data, m_ctrl[4 + d] ? m_a[d][15:0] : 16'd0};
    m_a[d] = res;
    m_lmi = res[35];
    m_leq = (res == 36'd0);
  endtask

  task automatic acc(logic [1:0] op, logic d, logic [15:0] data);
    acc_go = 1; acc_op = op; acc_dst = d; opnd = data;
    @(posedge clk); #1;
    acc_go = 0;
    model_acc(op, d, data);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk_read(3'd0, 16'h0000, "R1 reset ctrl");
    chk_state("R8 reset state");

    wr_reg(3'd0, 16'hFFFF);
    chk_read(3'd0, 16'h01FF, "R1 upper bits zero");
    wr_reg(3'd0, 16'h0000);
    chk_read(3'd0, 16'h0000, "R1 cleared");

    ld(0, 16'd3);
    ld(1, 16'd5);
    chk_read(3'd2, 16'd3, "R11 x read");
    chk_read(3'd3, 16'd5, "R11 y high read");
    chk_read(3'd4, 16'd0, "R11 y low read");
    chk_read(3'd7, 16'd0, "R11 unused addr");

    for (int a = 0; a < 4; a++) begin
      wr_reg(3'd0, 16'(a));
      acc(2'd2, 1'b0, 16'd0);
      chk_state($sformatf("R2 align %0d", a));
    end
    ld(0, 16'hFFF9);
    ld(1, 16'd3);
    wr_reg(3'd0, 16'h0001);
    acc(2'd2, 1'b1, 16'd0);
    chk_state("R2 negative divide by 4");

    wr_reg(3'd0, 16'h0000);
    acc(2'd0, 1'b1, 16'd0);
    chk_state("R3 add");
    acc(2'd1, 1'b1, 16'd0);
    acc(2'd1, 1'b1, 16'd0);
    chk_state("R3 sub, R5 minus");
    acc(2'd0, 1'b1, 16'd0);
    acc(2'd0, 1'b1, 16'd0);
    chk_state("R5 equal zero");

    // R4: x load and command in the same cycle use the old x
    opnd = 16'd100; ld_x = 1; acc_go = 1; acc_op = 2'd2; acc_dst = 1'b0;
    @(posedge clk); #1;
    ld_x = 0; acc_go = 0;
    model_acc(2'd2, 1'b0, 16'd100);
    m_x = 16'd100;
    chk_state("R4 old operand used");
    chk_read(3'd2, 16'd100, "R4 x loaded");

    wr_reg(3'd0, 16'h0002);
    ld(0, 16'h7FFF);
    ld(1, 16'h7FFF);
    acc(2'd3, 1'b0, 16'd0);
    for (int i = 0; i < 9; i++) begin
      acc(2'd0, 1'b0, 16'd0);
      chk_state($sformatf("R6 R7 positive climb %0d", i));
    end
    chk_read(3'd1, mstat(), "R8 sticky a0 set");
    acc(2'd0, 1'b1, 16'd0);
    chk_state("R8 sticky a0 holds");
    wr_reg(3'd1, 16'h0000);
    chk_state("R8 sticky cleared");

    wr_reg(3'd0, 16'h000A);
    acc(2'd3, 1'b1, 16'd0);
    for (int i = 0; i < 9; i++) acc(2'd0, 1'b1, 16'd0);
    chk_state("R6 a1 wraps when disabled");

    wr_reg(3'd0, 16'h0002);
    acc(2'd3, 1'b0, 16'd0);
    for (int i = 0; i < 9; i++) acc(2'd1, 1'b0, 16'd0);
    chk_state("R6 negative clamp");

    wr_reg(3'd0, 16'h0000);
    acc(2'd3, 1'b0, 16'hFFFF);
    ld(0, 16'h0100);
    ld(1, 16'h0100);
    acc(2'd0, 1'b0, 16'd0);
    chk_state("R7 carry out, R5 zero");
    acc(2'd1, 1'b0, 16'd0);
    chk_state("R7 borrow");

    ld(0, 16'd3);
    ld(1, 16'd5);
    acc(2'd2, 1'b1, 16'd0);
    wr_reg(3'd0, 16'h0020);
    acc(2'd3, 1'b1, 16'h0002);
    chk_state("R9 a1 low kept");
    wr_reg(3'd0, 16'h0000);
    acc(2'd3, 1'b1, 16'h0002);
    chk_state("R9 a1 low cleared");
    acc(2'd2, 1'b0, 16'd0);
    wr_reg(3'd0, 16'h0010);
    acc(2'd3, 1'b0, 16'h8001);
    chk_state("R9 a0 low kept");

    ld(2, 16'h1234);
    wr_reg(3'd0, 16'h0040);
    ld(1, 16'h0001);
    chk_read(3'd4, 16'h1234, "R9 y low kept");
    wr_reg(3'd0, 16'h0000);
    ld(1, 16'h0002);
    chk_read(3'd4, 16'h0000, "R9 y low cleared");

    wr_reg(3'd0, 16'h0080);
    ld(1, 16'hFFF7);
    chk_read(3'd2, 16'hFFF7, "R10 x follows y high");
    acc(2'd2, 1'b0, 16'd0);
    chk_state("R10 square");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule